// File: doc/BRIEF.md
# Translation-Storage-Buffer Pointer Register Bank

This block is a small register bank for a memory-management unit. It stores the buffer base registers for two page-size sets and a size configuration register. Each of these exists twice: one copy serves accesses whose context is zero and the other serves every other context. The bank also stores the tag-access register, which holds the faulting virtual address together with its context.

A single indexed read port returns any stored register. It can also return one of two computed pointers into the translation buffer, or a tag-target word built from the tag-access register. A pointer is built from three parts. The upper bits come from the chosen base register. The middle bits come from the tag-access value, shifted right by an amount that grows by three bits per page-size step. For the second set only, an optional split-buffer bit is added. Software or a miss handler writes the registers and reads back the ready-made pointer one cycle later.

Top module: `tsb_ptr_regs`

## Requirements
- R1: After reset every stored register is zero and `rvalid_o` and `rerr_o` are low; a read of any implemented index then returns zero.
- R2: A read requested with `rd_en_i` in one cycle presents `rdata_o` with `rvalid_o` high in the next cycle only; `rvalid_o` is low in every cycle that does not follow a request.
- R3: Indices 0 to 5 are full 64-bit read/write registers: 0 set-0 base, 1 set-1 base and 2 configuration for context zero; 3, 4 and 5 the same three for non-zero contexts.
- R4: Index 6 is the tag-access register; a write stores bits 59:0 of the data and fills bits 63:60 with copies of bit 59.
- R5: The pointers use registers 0 to 2 when tag-access bits 12:0 are all zero, and registers 3 to 5 otherwise.
- R6: Index 8 returns the set-0 pointer. Bits 63:13 of the base are OR-ed with the tag-access value shifted right by 9+3·S, where S is configuration bits 2:0. The shifted value is masked to bits 12+N down to 4, where N is base bits 3:0.
- R7: Index 9 returns the set-1 pointer, formed as in R6 but with S taken from configuration bits 10:8. In addition, bit 13+N is set whenever base bit 12 is set.
- R8: Index 10 returns the tag target. Bits 41:0 hold tag-access bits 63:22, bits 60:48 hold tag-access bits 12:0, and all other bits are zero.
- R9: A read of index 7 or 11 to 15 returns zero with `rerr_o` high for that cycle; `rerr_o` is low for every other read. A write to any index from 7 to 15 changes no register.
- R10: A read and a write issued in the same cycle to the same register return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read request |
| idx_i | input | 4 | Register index for read and write |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid one cycle after the request |
| rvalid_o | output | 1 | Read data valid |
| rerr_o | output | 1 | Read hit an unimplemented index |

## Verification
The assertions assume that the read and write strobes are clean 0/1 values and that the index is stable in any cycle where a strobe is high. They make no assumption about the contents of the registers: every base, configuration and tag-access value is legal. The stimulus changes the inputs only on the falling edge and keeps both strobes low between operations, except in the one deliberate same-cycle read/write case. It sweeps every page-size code and every value of N, with the split bit both set and clear, and for both zero and non-zero contexts.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int DATA_W     = 64;
  localparam int CTX_W      = 13;
  localparam int SEXT_BIT   = 59;
  localparam int BASE_LSB   = 13;
  localparam int SZ_W       = 3;
  localparam int N_W        = 4;
  localparam int SHIFT_BASE = 9;
  localparam int SHIFT_STEP = 3;
  localparam int TT_VA_LSB  = 22;
  localparam int TT_CTX_LSB = 48;
  localparam int NUM_COPIES = 2;

  typedef enum logic [3:0] {
    IDX_BASE0_Z = 4'd0,
    IDX_BASE1_Z = 4'd1,
    IDX_CFG_Z   = 4'd2,
    IDX_BASE0_X = 4'd3,
    IDX_BASE1_X = 4'd4,
    IDX_CFG_X   = 4'd5,
    IDX_TAG     = 4'd6,
    IDX_PTR0    = 4'd8,
    IDX_PTR1    = 4'd9,
    IDX_TGT     = 4'd10
  } reg_idx_e;

  typedef struct packed {
    logic [DATA_W-1:0] base0;
    logic [DATA_W-1:0] base1;
    logic [DATA_W-1:0] cfg;
  } tsb_copy_t;

  function automatic logic [DATA_W-1:0] sext_tag(input logic [DATA_W-1:0] d);
    return {{(DATA_W-1-SEXT_BIT){d[SEXT_BIT]}}, d[SEXT_BIT:0]};
  endfunction
endpackage

// File: rtl/tsb_reg_bank.sv
module tsb_reg_bank
  import tsb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output tsb_copy_t         copy_o [NUM_COPIES],
  output logic [DATA_W-1:0] tag_o
);
  localparam int FIELDS = 3;

  tsb_copy_t         copy_q [NUM_COPIES];
  logic [DATA_W-1:0] tag_q;

  for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
    localparam logic [IDX_W-1:0] B0 = IDX_W'(g*FIELDS);
    localparam logic [IDX_W-1:0] B1 = IDX_W'(g*FIELDS + 1);
    localparam logic [IDX_W-1:0] CF = IDX_W'(g*FIELDS + 2);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        copy_q[g] <= '0;
      end else if (wr_en_i) begin
        if (idx_i == B0) copy_q[g].base0 <= wdata_i;
        if (idx_i == B1) copy_q[g].base1 <= wdata_i;
        if (idx_i == CF) copy_q[g].cfg   <= wdata_i;
      end
    end
    assign copy_o[g] = copy_q[g];

    // R3
    cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && idx_i == CF) |=> (copy_q[g].cfg == $past(wdata_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   tag_q <= '0;
    else if (wr_en_i && idx_i == IDX_W'(IDX_TAG))  tag_q <= sext_tag(wdata_i);
  end
  assign tag_o = tag_q;

  // R4
  tag_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_W'(IDX_TAG)) |=>
      (tag_q[DATA_W-1:SEXT_BIT] == {(DATA_W-SEXT_BIT){$past(wdata_i[SEXT_BIT])}}
       && tag_q[SEXT_BIT-1:0] == $past(wdata_i[SEXT_BIT-1:0])));

  // R9
  high_idx_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i > IDX_W'(IDX_TAG)) |=> $stable(tag_q));
endmodule

// File: rtl/tsb_ptr_calc.sv
module tsb_ptr_calc
  import tsb_pkg::*;
#(
  parameter int SET_SEL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] cfg_i,
  input  logic [DATA_W-1:0] tag_i,
  output logic [DATA_W-1:0] ptr_o
);
  localparam int SH_W  = 6;
  localparam int TOP_K = BASE_LSB + (1 << N_W);

  logic [N_W-1:0]    n;
  logic [SZ_W-1:0]   sz;
  logic [SH_W-1:0]   shamt;
  logic [SH_W-1:0]   hi_pos;
  logic [DATA_W-1:0] shifted, mask, split_bit;

  assign n = base_i[N_W-1:0];

  if (SET_SEL == 0) begin : g_set0
    assign sz        = cfg_i[SZ_W-1:0];
    assign split_bit = '0;
  end else begin : g_set1
    assign sz        = cfg_i[8 +: SZ_W];
    assign split_bit = DATA_W'(base_i[12]) << hi_pos;
  end

  assign shamt   = SH_W'(SHIFT_BASE) + {{(SH_W-SZ_W){1'b0}}, sz} * SH_W'(SHIFT_STEP);
  assign hi_pos  = SH_W'(BASE_LSB) + {{(SH_W-N_W){1'b0}}, n};
  assign shifted = tag_i >> shamt;
  assign mask    = ((DATA_W'(1) << hi_pos) - DATA_W'(1)) & ~DATA_W'(15);
  assign ptr_o   = {base_i[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}} | (shifted & mask) | split_bit;

  // R6
  ptr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[3:0] == 4'd0);
  // R7
  ptr_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[DATA_W-1:TOP_K] == base_i[DATA_W-1:TOP_K]);
endmodule

// File: rtl/tsb_ptr_regs.sv
module tsb_ptr_regs
  import tsb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              rerr_o
);
  localparam int NUM_SETS = 2;

  tsb_copy_t         copy [NUM_COPIES];
  tsb_copy_t         act;
  logic [DATA_W-1:0] tag, tgt;
  logic [DATA_W-1:0] ptr [NUM_SETS];
  logic              ctx_zero;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_bad;

  tsb_reg_bank #(.IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .idx_i, .wdata_i,
    .copy_o(copy), .tag_o(tag)
  );

  // copy 0 serves context zero
  assign ctx_zero = (tag[CTX_W-1:0] == '0);
  assign act      = ctx_zero ? copy[0] : copy[1];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_ptr
    tsb_ptr_calc #(.SET_SEL(s)) u_calc (
      .clk_i, .rst_ni,
      .base_i(s == 0 ? act.base0 : act.base1),
      .cfg_i (act.cfg),
      .tag_i (tag),
      .ptr_o (ptr[s])
    );
  end

  assign tgt = (DATA_W'(tag[DATA_W-1:TT_VA_LSB])) |
               (DATA_W'(tag[CTX_W-1:0]) << TT_CTX_LSB);

  always_comb begin
    rd_mux = '0;
    rd_bad = 1'b0;
    case (idx_i)
      IDX_W'(IDX_BASE0_Z): rd_mux = copy[0].base0;
      IDX_W'(IDX_BASE1_Z): rd_mux = copy[0].base1;
      IDX_W'(IDX_CFG_Z):   rd_mux = copy[0].cfg;
      IDX_W'(IDX_BASE0_X): rd_mux = copy[1].base0;
      IDX_W'(IDX_BASE1_X): rd_mux = copy[1].base1;
      IDX_W'(IDX_CFG_X):   rd_mux = copy[1].cfg;
      IDX_W'(IDX_TAG):     rd_mux = tag;
      IDX_W'(IDX_PTR0):    rd_mux = ptr[0];
      IDX_W'(IDX_PTR1):    rd_mux = ptr[1];
      IDX_W'(IDX_TGT):     rd_mux = tgt;
      default:             rd_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      rerr_o   <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      rerr_o   <= rd_en_i & rd_bad;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  // R2
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  // R2
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  // R9
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> (rvalid_o && rdata_o == '0));
  // R8
  tgt_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && idx_i == IDX_W'(IDX_TGT)) |=>
      (rdata_o[TT_CTX_LSB-1:DATA_W-TT_VA_LSB] == '0 && rdata_o[DATA_W-1:TT_CTX_LSB+CTX_W] == '0));
endmodule

// File: tb/tsb_ptr_regs_test.sv
module tsb_ptr_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  idx = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rvalid, rerr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tsb_ptr_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .idx_i(idx), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .rerr_o(rerr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [63:0] d);
    @(negedge clk); wr_en = 1; idx = i; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [63:0] d, output logic e, output logic v);
    @(negedge clk); rd_en = 1; idx = i;
    @(negedge clk); rd_en = 0; d = rdata; e = rerr; v = rvalid;
  endtask

  function automatic logic [63:0] mix(input int x);
    logic [63:0] h = 64'(x) * 64'h9E3779B97F4A7C15 + 64'h1234_5678_9ABC_DEF1;
    return h ^ (h >> 29) ^ (h << 17);
  endfunction

  function automatic logic [63:0] sx(input logic [63:0] d);
    logic [63:0] r = d;
    for (int b = 60; b < 64; b++) r[b] = d[59];
    return r;
  endfunction

  function automatic logic [63:0] model_ptr(input logic [63:0] base, input logic [63:0] cfg,
                                            input logic [63:0] tag, input bit set1);
    logic [63:0] p = base & ~64'h1FFF;
    int n = int'(base[3:0]);
    int s = set1 ? int'(cfg[10:8]) : int'(cfg[2:0]);
    int sh = 9 + 3 * s;
    for (int b = 4; b <= 12 + n; b++)
      if (b + sh < 64 && tag[b + sh]) p[b] = 1'b1;
    if (set1 && base[12]) p[13 + n] = 1'b1;
    return p;
  endfunction

  function automatic logic [63:0] model_tgt(input logic [63:0] tag);
    logic [63:0] t = '0;
    for (int b = 0; b < 42; b++) t[b] = tag[b + 22];
    for (int b = 0; b < 13; b++) t[48 + b] = tag[b];
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, exp_p, tg, b0, b1, cf;
    logic e, v;
    logic [63:0] shadow [7];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rvalid && !rerr, "R1 flags", {62'd0, rvalid, rerr}, 0);
    rst_n = 1;
    for (int i = 0; i < 11; i++) begin
      if (i == 7) continue;
      rd(4'(i), d, e, v);
      chk(d == 0 && !e, "R1 reset read", d, 0);
    end
    // R2 valid timing
    rd(4'd0, d, e, v);
    chk(v, "R2 rvalid high", 64'(v), 1);
    @(negedge clk);
    chk(!rvalid, "R2 rvalid idle", 64'(rvalid), 0);
    // R3 / R4 write and read back
    for (int i = 0; i < 7; i++) begin
      shadow[i] = mix(i + 100);
      wr(4'(i), shadow[i]);
      if (i == 6) shadow[i] = sx(shadow[i]);
    end
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), d, e, v);
      chk(d == shadow[i] && !e, i == 6 ? "R4 tag sext" : "R3 readback", d, shadow[i]);
    end
    wr(4'd6, 64'h0800_0000_0000_0000);
    rd(4'd6, d, e, v);
    chk(d == 64'hF800_0000_0000_0000, "R4 sext ones", d, 64'hF800_0000_0000_0000);
    wr(4'd6, 64'hF7FF_FFFF_FFFF_FFFF);
    rd(4'd6, d, e, v);
    chk(d == 64'h07FF_FFFF_FFFF_FFFF, "R4 sext zeros", d, 64'h07FF_FFFF_FFFF_FFFF);
    shadow[6] = 64'h07FF_FFFF_FFFF_FFFF;
    // R9 unimplemented reads and ignored writes
    for (int i = 7; i < 16; i++) begin
      if (i >= 8 && i <= 10) begin
        rd(4'(i), d, e, v);
        chk(!e, "R9 no err", 64'(e), 0);
      end else begin
        rd(4'(i), d, e, v);
        chk(d == 0 && e && v, "R9 unimpl read", d, 0);
      end
      wr(4'(i), 64'hDEAD_BEEF_0000_0001);
    end
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), d, e, v);
      chk(d == shadow[i], "R9 write ignored", d, shadow[i]);
    end
    // R10 same-cycle read and write
    @(negedge clk); wr_en = 1; rd_en = 1; idx = 4'd1; wdata = 64'h5555_AAAA_5555_AAAA;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk(rdata == shadow[1], "R10 old value", rdata, shadow[1]);
    rd(4'd1, d, e, v);
    chk(d == 64'h5555_AAAA_5555_AAAA, "R10 new value", d, 64'h5555_AAAA_5555_AAAA);
    // R5 R6 R7 R8 sweep
    for (int cz = 0; cz < 2; cz++)
      for (int n = 0; n < 16; n++)
        for (int s = 0; s < 8; s++)
          for (int sp = 0; sp < 2; sp++) begin
            int k = ((cz * 16 + n) * 8 + s) * 2 + sp;
            b0 = mix(k * 3);     b0[3:0] = 4'(n); b0[12] = 1'(sp);
            b1 = mix(k * 3 + 1); b1[3:0] = 4'(n); b1[12] = 1'(sp);
            cf = mix(k * 3 + 2); cf[2:0] = 3'(s); cf[10:8] = 3'(7 - s);
            tg = sx(mix(k + 5000));
            if (cz == 0) tg[12:0] = '0; else tg[0] = 1'b1;
            wr(cz == 0 ? 4'd0 : 4'd3, b0);
            wr(cz == 0 ? 4'd1 : 4'd4, b1);
            wr(cz == 0 ? 4'd2 : 4'd5, cf);
            wr(4'd6, tg);
            exp_p = model_ptr(b0, cf, tg, 0);
            rd(4'd8, d, e, v);
            chk(d == exp_p, cz == 0 ? "R5 R6 ptr0 ctx0" : "R5 R6 ptr0 ctxn", d, exp_p);
            exp_p = model_ptr(b1, cf, tg, 1);
            rd(4'd9, d, e, v);
            chk(d == exp_p, sp ? "R7 ptr1 split" : "R7 ptr1", d, exp_p);
            if (s == 0 && sp == 0) begin
              rd(4'd10, d, e, v);
              chk(d == model_tgt(tg), "R8 tag target", d, model_tgt(tg));
            end
          end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule